// File: doc/BRIEF.md
# Converter Serial Master Readout

This block is the digital readout side of a sampling converter that drives its own serial link. The host pulses a convert-start input. A counter then times the conversion, and at its last cycle the result is taken from a parallel sample input into a holding register. The block generates the serial clock itself by dividing the system clock. It shifts each result out most significant bit first on one data line. A frame-valid strobe stays active for exactly the span of the 16 data bits, and a busy flag tells the host when a conversion or readout is in progress.

A mode input, captured when a conversion is accepted, picks one of two timings. In the after-conversion timing, the new result is sent at once when the conversion ends, and busy stays high until the last bit has gone. In the during-conversion timing, the frame starts together with the conversion and carries the previous result, while busy drops as soon as the conversion counter expires. Two polarity inputs can invert the serial clock and the frame strobe.

The serial output has no back-pressure: the host cannot stall a frame, and it must capture each bit inside the window the serial clock marks. The control pins are plain levels and pulses.

Top module: `conv_serial_readout`

## Requirements
- R1: After reset, busy is low, the frame strobe is inactive, the data line is low and the serial clock sits at its idle level.
- R2: A start pulse seen while busy is low and no frame is in flight is accepted: busy is high from the next cycle.
- R3: A start pulse seen while busy is high or while a frame is in flight is ignored. The frame in progress and the busy timing continue unchanged, and no new conversion begins.
- R4: Each frame carries 16 bits, most significant bit first. Every bit is held for CLK_DIV system cycles and changes only at a bit boundary.
- R5: In each bit period the internal serial clock is high from cycle CLK_DIV/4 to cycle 3*CLK_DIV/4-1 of that period, counting from 0. A frame therefore has 16 rising and 16 falling edges, each a quarter period away from a data change.
- R6: The frame strobe is active for exactly 16*CLK_DIV consecutive cycles, which covers every cycle in which a data bit is driven.
- R7: The serial clock output is the internal clock XOR the clock-invert input, and the strobe output is the active flag XOR the strobe-invert input. This also applies when idle.
- R8: When mode is 0 (after conversion), the frame starts CONV_CYCLES cycles after acceptance and carries the new result. Busy stays high until the last bit has been sent and falls in the same cycle as the strobe.
- R9: When mode is 1 (during conversion), the frame starts the cycle after acceptance and carries the previously converted result, which is zero after reset. Busy is high for exactly CONV_CYCLES cycles.
- R10: The sample input is captured only in the last conversion cycle. Changes to it after that cycle do not alter the frame being sent.
- R11: Outside a frame the data line is driven low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Convert-start pulse |
| mode_i | input | 1 | 0: send after conversion, 1: send previous result during conversion |
| sample_i | input | DATA_W | Conversion result, captured at conversion end |
| clk_inv_i | input | 1 | Invert the serial clock output |
| sync_inv_i | input | 1 | Invert the frame strobe output |
| busy_o | output | 1 | Conversion or readout in progress |
| sclk_o | output | 1 | Generated serial clock |
| sync_o | output | 1 | Frame-valid strobe |
| sdata_o | output | 1 | Serial data, MSB first |

## Verification
The bench builds the block with CLK_DIV=4 and CONV_CYCLES=10. With these values a frame is 64 cycles long, which is longer than the conversion. In the during-conversion mode this leaves a stretch where busy is already low but the frame is still running, and the bench fires a start pulse into that stretch. With the short conversion, every combination of mode, clock polarity and strobe polarity can be swept over walking-one words and dense patterns, and the waveform is compared cycle by cycle against values worked out from the bit index and the phase within the bit.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_SHIFT = 2'd2
  } csr_state_t;

  localparam logic MODE_AFTER  = 1'b0;
  localparam logic MODE_DURING = 1'b1;
endpackage

// File: rtl/csr_conv_timer.sv
module csr_conv_timer #(
  parameter int CONV_CYCLES = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick_i,
  output logic running_o,
  output logic done_o
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  // done marks the final conversion cycle
  assign done_o    = run_q && (cnt_q == LAST);
  assign running_o = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (kick_i) begin
      cnt_q <= '0;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == LAST) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/csr_frame_timer.sv
module csr_frame_timer #(
  parameter int CLK_DIV = 4,
  parameter int NBITS   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic active_o,
  output logic sclk_o,
  output logic bit_tick_o,
  output logic last_o
);
  localparam int PH_W  = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = (NBITS > 1) ? $clog2(NBITS) : 1;
  localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(NBITS - 1);

  logic [PH_W-1:0]  ph_q;
  logic [BIT_W-1:0] bit_q;
  logic             act_q;

  assign bit_tick_o = act_q && (ph_q == PH_LAST);
  assign last_o     = bit_tick_o && (bit_q == BIT_LAST);
  assign active_o   = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q  <= '0;
      bit_q <= '0;
      act_q <= 1'b0;
    end else if (load_i) begin
      ph_q  <= '0;
      bit_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (ph_q == PH_LAST) begin
        ph_q  <= '0;
        bit_q <= bit_q + 1'b1;
        if (bit_q == BIT_LAST) act_q <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end

  // Clock placement: centred in the bit when the divider allows quarters
  generate
    if (CLK_DIV >= 4) begin : g_quarter
      localparam logic [PH_W-1:0] RISE = PH_W'(CLK_DIV / 4);
      localparam logic [PH_W-1:0] FALL = PH_W'(3 * (CLK_DIV / 4));
      assign sclk_o = act_q && (ph_q >= RISE) && (ph_q < FALL);
    end else begin : g_half
      localparam logic [PH_W-1:0] RISE = PH_W'(CLK_DIV / 2);
      assign sclk_o = act_q && (ph_q >= RISE);
    end
  endgenerate
endmodule

// File: rtl/csr_shift_reg.sv
module csr_shift_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [DATA_W-1:0] load_val_i,
  input  logic              shift_i,
  output logic              msb_o
);
  logic [DATA_W-1:0] sr_q;

  assign msb_o = sr_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (load_i) begin
      sr_q <= load_val_i;
    end else if (shift_i) begin
      sr_q <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/conv_serial_readout.sv
module conv_serial_readout
  import csr_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CLK_DIV     = 4,
  parameter int CONV_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              clk_inv_i,
  input  logic              sync_inv_i,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              sync_o,
  output logic              sdata_o
);
  csr_state_t        state_q;
  logic              mode_q;
  logic [DATA_W-1:0] hold_q;

  logic conv_run, conv_done;
  logic frm_active, frm_sclk, frm_tick, frm_last;
  logic sr_msb;
  logic accept, frm_load;
  logic [DATA_W-1:0] load_val;

  // A new conversion needs both the FSM idle and the serial line free
  assign accept   = start_i && (state_q == ST_IDLE) && !frm_active;
  assign frm_load = (accept && (mode_i == MODE_DURING)) ||
                    ((state_q == ST_CONV) && conv_done && (mode_q == MODE_AFTER));
  assign load_val = (state_q == ST_CONV) ? sample_i : hold_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_AFTER;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q <= ST_CONV;
            mode_q  <= mode_i;
          end
        end
        ST_CONV: begin
          if (conv_done) begin
            hold_q  <= sample_i;
            state_q <= (mode_q == MODE_DURING) ? ST_IDLE : ST_SHIFT;
          end
        end
        ST_SHIFT: begin
          if (frm_last) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  csr_conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_i    (accept),
    .running_o (conv_run),
    .done_o    (conv_done)
  );

  csr_frame_timer #(.CLK_DIV(CLK_DIV), .NBITS(DATA_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (frm_load),
    .active_o   (frm_active),
    .sclk_o     (frm_sclk),
    .bit_tick_o (frm_tick),
    .last_o     (frm_last)
  );

  csr_shift_reg #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (frm_load),
    .load_val_i (load_val),
    .shift_i    (frm_tick),
    .msb_o      (sr_msb)
  );

  assign busy_o  = (state_q != ST_IDLE) || conv_run;
  assign sclk_o  = frm_sclk ^ clk_inv_i;
  assign sync_o  = frm_active ^ sync_inv_i;
  assign sdata_o = frm_active & sr_msb;
endmodule

// File: rtl/csr_checker.sv
module csr_checker #(
  parameter int DATA_W      = 16,
  parameter int CLK_DIV     = 4,
  parameter int CONV_CYCLES = 40
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic sclk_o,
  input logic sync_o,
  input logic sdata_o,
  input logic clk_inv_i,
  input logic sync_inv_i,
  input logic mode_q
);
  localparam int FRAME = DATA_W * CLK_DIV;
  localparam int CW    = $clog2(FRAME + CONV_CYCLES + 2) + 1;

  logic sync_act, sclk_act;
  logic [CW-1:0] frm_cnt, busy_cnt;

  assign sync_act = sync_o ^ sync_inv_i;
  assign sclk_act = sclk_o ^ clk_inv_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_cnt  <= '0;
      busy_cnt <= '0;
    end else begin
      frm_cnt  <= sync_act ? frm_cnt + 1'b1 : '0;
      busy_cnt <= busy_o ? busy_cnt + 1'b1 : '0;
    end
  end

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o && !sync_act |=> busy_o);

  p_ignore_tail_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && sync_act && !busy_o |=> !busy_o);

  p_data_at_boundary_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdata_o) && sync_act && $past(sync_act) |-> !sclk_act && !$past(sclk_act));

  p_clk_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_act |-> sync_act);

  p_frame_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_act) |-> frm_cnt == CW'(FRAME));

  p_busy_with_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) && !mode_q |-> $fell(sync_act));

  p_busy_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) && mode_q |-> busy_cnt == CW'(CONV_CYCLES));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_act |-> !sdata_o && !sclk_act);
endmodule

bind conv_serial_readout csr_checker #(
  .DATA_W(DATA_W), .CLK_DIV(CLK_DIV), .CONV_CYCLES(CONV_CYCLES)
) u_chk (.*);

// File: tb/conv_serial_readout_bench.sv
module conv_serial_readout_bench;
  localparam int D  = 4;
  localparam int C  = 10;
  localparam int W  = 16;
  localparam int FR = W * D;
  localparam int Q  = D / 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic mode_i = 1'b0;
  logic [W-1:0] sample_i = '0;
  logic cinv = 1'b0;
  logic sinv = 1'b0;
  logic busy_o, sclk_o, sync_o, sdata_o;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] prev = '0;

  always #10 clk = ~clk;

  conv_serial_readout #(.DATA_W(W), .CLK_DIV(D), .CONV_CYCLES(C)) u_conv_serial_readout (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .sample_i(sample_i), .clk_inv_i(cinv), .sync_inv_i(sinv),
    .busy_o(busy_o), .sclk_o(sclk_o), .sync_o(sync_o), .sdata_o(sdata_o)
  );

  task automatic chk(input string tag, input int k, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s k=%0d got=%0b exp=%0b", tag, k, got, exp);
    end
  endtask

  task automatic run_frame(input logic m, input logic [W-1:0] w, input bit inject);
    int fs, fe, be, injk, last, j, b, ph;
    logic [W-1:0] fw;
    logic act, e_sc;
    string tb_, ts;
    fs   = m ? 0 : C;
    fe   = fs + FR;
    be   = m ? C : fe;
    fw   = m ? prev : w;
    injk = m ? C + 2 : 3;
    last = ((be > fe) ? be : fe) + 2;
    @(negedge clk);
    sample_i = w; mode_i = m; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k <= last; k++) begin
      act = (k >= fs) && (k < fe);
      j = k - fs; b = j / D; ph = j % D;
      e_sc = act && (ph >= Q) && (ph < 3 * Q);
      tb_ = (k == 0) ? "R2" : ((inject && k > injk) ? "R3" : (m ? "R9" : "R8"));
      chk(tb_, k, busy_o, k < be);
      ts = act ? ((!m && k > C) ? "R10" : "R4") : "R11";
      chk(ts, k, sdata_o, act ? fw[W-1-b] : 1'b0);
      chk(cinv ? "R7" : "R5", k, sclk_o, e_sc ^ cinv);
      chk(sinv ? "R7" : "R6", k, sync_o, act ^ sinv);
      start_i = inject && (k == injk);
      if (k == C) sample_i = ~w;
      @(negedge clk);
    end
    start_i = 1'b0;
    if (inject) begin
      chk("R3", last + 1, busy_o, 1'b0);
      chk("R3", last + 1, sync_o, sinv);
    end
    prev = w;
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [W-1:0] word;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", 0, busy_o, 1'b0);
    chk("R1", 0, sync_o, 1'b0);
    chk("R1", 0, sdata_o, 1'b0);
    chk("R1", 0, sclk_o, 1'b0);
    // first during-conversion frame after reset carries zero (R9)
    run_frame(1'b1, 16'h1234, 1'b0);
    for (int ci = 0; ci < 2; ci++) begin
      for (int si = 0; si < 2; si++) begin
        @(negedge clk);
        cinv = ci[0]; sinv = si[0];
        @(negedge clk);
        chk("R7", 0, sclk_o, cinv);
        chk("R7", 0, sync_o, sinv);
        for (int md = 0; md < 2; md++) begin
          for (int p = 0; p < 20; p++) begin
            if (p < 16) word = W'(1) << p;
            else if (p == 16) word = '0;
            else if (p == 17) word = '1;
            else if (p == 18) word = 16'hA5C3;
            else word = 16'h3C5A ^ W'(ci * 3 + si * 5 + md);
            run_frame(md[0], word, (p % 5) == 2);
          end
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule